// File: doc/BRIEF.md
# TLB Replacement Pointer Counter

This block holds the pointer that names the slot of a 64-slot unified TLB which the next software TLB-load instruction will overwrite. The pointer advances by one on every TLB lookup. It wraps to zero when it reaches a programmable limit, or after slot 63 when no limit is set. Software reads and writes the pointer, the limit and two mode bits through one 32-bit control register that has per-byte write enables.

The block also flags a store-queue access made in user mode while the store queues are restricted to privileged code. Exception dispatch uses this flag. The TLB array, address translation and the exception logic itself sit outside this block.

Top module: `tlb_repl_ctl`

## Requirements
- R1: After reset, the pointer, the limit and both mode bits are zero, so `repl_idx_o` is 0 and `rd_data_o` is 0.
- R2: A cycle with `tlb_access_i` high, `tlb_load_i` low and no pointer write moves the pointer up by one. The new value appears on `repl_idx_o` and in `rd_data_o[15:10]` after the next rising clock edge.
- R3: When the limit is non-zero and the pointer equals the limit, a counting cycle sets the pointer to 0 instead of incrementing it.
- R4: When the limit is 0, the pointer counts freely through all 64 values, and a counting cycle at 63 wraps it to 0.
- R5: When software writes a pointer value above a non-zero limit, counting cycles carry the pointer up to 63 and then wrap it to 0. From then on it wraps at the limit again.
- R6: A cycle with `tlb_load_i` high never advances the pointer, even when `tlb_access_i` is also high. The load uses the current `repl_idx_o`.
- R7: When a pointer write and a counting cycle fall in the same cycle, the written value is stored and the increment for that cycle is dropped.
- R8: A write with `wr_be_i[1]` set loads the pointer from `wr_data_i[15:10]`, the store-queue restriction bit from `wr_data_i[9]` and the single-address-space mode bit from `wr_data_i[8]`. A write with `wr_be_i[2]` set loads the limit from `wr_data_i[23:18]`. A field whose byte lane is not enabled keeps its value.
- R9: All register bits other than 23:18, 15:10, 9 and 8 read as zero. Writes through byte lanes 0 and 3 change nothing.
- R10: `sq_viol_o` is high in the same cycle as `sq_user_acc_i` exactly when the restriction bit (bit 9) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tlb_access_i | input | 1 | One TLB lookup this cycle |
| tlb_load_i | input | 1 | A TLB-load instruction executes this cycle |
| wr_en_i | input | 1 | Control register write strobe |
| wr_be_i | input | 4 | Byte enables for the write |
| wr_data_i | input | 32 | Write data |
| sq_user_acc_i | input | 1 | User-mode store-queue access this cycle |
| repl_idx_o | output | 6 | Current replacement slot |
| rd_data_o | output | 32 | Control register read value |
| sq_viol_o | output | 1 | User access to store queues while they are restricted |

## Verification
Writes and counting cycles act on the pointer, the limit and the mode bits at one rising edge. `repl_idx_o` and `rd_data_o` show the new state in the half-cycle after that edge. `sq_viol_o` is combinational and is due in the same cycle as `sq_user_acc_i`. The bench drives each cycle's inputs on the falling edge and samples all outputs 1 ns later. It then moves its reference model at the following rising edge, so every sample compares the state from before that edge, plus the same-cycle violation flag, against the model.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BE_W    = REG_W / 8;
  localparam int unsigned CNT_LSB = 10;
  localparam int unsigned BND_LSB = 18;
  localparam int unsigned SQ_BIT  = 9;
  localparam int unsigned SV_BIT  = 8;
  localparam int unsigned CNT_LANE = CNT_LSB / 8;
  localparam int unsigned BND_LANE = BND_LSB / 8;
  localparam int unsigned MODE_LANE = SQ_BIT / 8;
endpackage

// File: rtl/tlb_repl_rst_sync.sv
module tlb_repl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tlb_repl_counter.sv
module tlb_repl_counter #(
  parameter int unsigned IDX_W = tlb_repl_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             cnt_we_i,
  input  logic [IDX_W-1:0] cnt_wdata_i,
  input  logic             bnd_we_i,
  input  logic [IDX_W-1:0] bnd_wdata_i,
  output logic [IDX_W-1:0] cnt_o,
  output logic [IDX_W-1:0] bnd_o
);
  localparam logic [IDX_W-1:0] ZERO = '0;
  localparam logic [IDX_W-1:0] ONE  = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] bnd_q, bnd_d;
  logic             cnt_en, bnd_en;
  logic             at_limit;

  always_comb begin
    at_limit = (bnd_q != ZERO) && (cnt_q == bnd_q);
    cnt_en   = cnt_we_i || step_i;
    cnt_d    = cnt_q;
    if (cnt_we_i)      cnt_d = cnt_wdata_i;
    else if (at_limit) cnt_d = ZERO;
    else               cnt_d = cnt_q + ONE;
    bnd_en = bnd_we_i;
    bnd_d  = bnd_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bnd_q <= '0;
    else if (bnd_en) bnd_q <= bnd_d;
  end

  assign cnt_o = cnt_q;
  assign bnd_o = bnd_q;

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !cnt_we_i && !((bnd_q != ZERO) && (cnt_q == bnd_q)))
      |=> cnt_q == IDX_W'($past(cnt_q) + 1));

  assert_limit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !cnt_we_i && bnd_q != ZERO && cnt_q == bnd_q) |=> cnt_q == ZERO);

  assert_top_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !cnt_we_i && cnt_q == '1) |=> cnt_q == ZERO);

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tlb_repl_mode.sv
module tlb_repl_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic sq_d_i,
  input  logic sv_d_i,
  output logic sq_o,
  output logic sv_o
);
  logic sq_q, sv_q;
  logic sq_d, sv_d;

  always_comb begin
    sq_d = sq_d_i;
    sv_d = sv_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q <= 1'b0;
      sv_q <= 1'b0;
    end else if (we_i) begin
      sq_q <= sq_d;
      sv_q <= sv_d;
    end
  end

  assign sq_o = sq_q;
  assign sv_o = sv_q;

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(sq_q) && $stable(sv_q)));
endmodule

// File: rtl/tlb_repl_ctl.sv
module tlb_repl_ctl
  import tlb_repl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tlb_access_i,
  input  logic             tlb_load_i,
  input  logic             wr_en_i,
  input  logic [BE_W-1:0]  wr_be_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             sq_user_acc_i,
  output logic [IDX_W-1:0] repl_idx_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             sq_viol_o
);
  logic             rst_n_s;
  logic             cnt_we, bnd_we, mode_we, step;
  logic [IDX_W-1:0] cnt, bnd;
  logic             sq_mode, sv_mode;

  tlb_repl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  always_comb begin
    cnt_we  = wr_en_i && wr_be_i[CNT_LANE];
    bnd_we  = wr_en_i && wr_be_i[BND_LANE];
    mode_we = wr_en_i && wr_be_i[MODE_LANE];
    step    = tlb_access_i && !tlb_load_i;
  end

  tlb_repl_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .step_i      (step),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (wr_data_i[CNT_LSB +: IDX_W]),
    .bnd_we_i    (bnd_we),
    .bnd_wdata_i (wr_data_i[BND_LSB +: IDX_W]),
    .cnt_o       (cnt),
    .bnd_o       (bnd)
  );

  tlb_repl_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .we_i   (mode_we),
    .sq_d_i (wr_data_i[SQ_BIT]),
    .sv_d_i (wr_data_i[SV_BIT]),
    .sq_o   (sq_mode),
    .sv_o   (sv_mode)
  );

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[BND_LSB +: IDX_W]    = bnd;
    rd_data_o[CNT_LSB +: IDX_W]    = cnt;
    rd_data_o[SQ_BIT]              = sq_mode;
    rd_data_o[SV_BIT]              = sv_mode;
    repl_idx_o                     = cnt;
    sq_viol_o                      = sq_user_acc_i && sq_mode;
  end

  assert_load_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tlb_load_i && !cnt_we) |=> repl_idx_o == $past(repl_idx_o));

  assert_viol_seen_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sq_user_acc_i && rd_data_o[SQ_BIT]) |-> sq_viol_o);

  assert_viol_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sq_user_acc_i |-> !sq_viol_o);
endmodule

// File: tb/tlb_repl_ctl_bench.sv
module tlb_repl_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc = 1'b0, ld = 1'b0, we = 1'b0, usr = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [5:0]  idx;
  logic [31:0] rd;
  logic        viol;

  int checks = 0;
  int fails  = 0;
  int m_cnt = 0, m_bnd = 0, m_sq = 0, m_sv = 0;

  always #2 clk = ~clk;

  tlb_repl_ctl u_tlb_repl_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .tlb_access_i  (acc),
    .tlb_load_i    (ld),
    .wr_en_i       (we),
    .wr_be_i       (be),
    .wr_data_i     (wd),
    .sq_user_acc_i (usr),
    .repl_idx_o    (idx),
    .rd_data_o     (rd),
    .sq_viol_o     (viol)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic l, input logic w, input logic [3:0] b,
                      input logic [31:0] d, input logic u, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    acc = a; ld = l; we = w; be = b; wd = d; usr = u;
    #1;
    exp_rd = (32'(m_bnd) << 18) | (32'(m_cnt) << 10) | (32'(m_sq) << 9) | (32'(m_sv) << 8);
    check(tag, "idx", idx, m_cnt);
    check(tag, "rd", rd, exp_rd);
    check(tag, "viol", viol, (u && m_sq != 0) ? 1 : 0);
    @(posedge clk);
    if (w && b[1]) begin
      m_cnt = int'(d[15:10]); m_sq = int'(d[9]); m_sv = int'(d[8]);
    end else if (a && !l) begin
      if (m_bnd != 0 && m_cnt == m_bnd) m_cnt = 0;
      else m_cnt = (m_cnt + 1) % 64;
    end
    if (w && b[2]) m_bnd = int'(d[23:18]);
  endtask

  function automatic logic [31:0] fld(input int bnd, input int cnt, input int sq, input int sv);
    return (32'(bnd) << 18) | (32'(cnt) << 10) | (32'(sq) << 9) | (32'(sv) << 8);
  endfunction

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(0, 0, 0, 4'h0, 0, 0, "R1");                       // reset state
    for (int i = 0; i < 5; i++) step(1, 0, 0, 4'h0, 0, 0, "R2");
    step(0, 0, 1, 4'b0100, fld(7, 0, 0, 0), 0, "R8");      // limit = 7 only
    for (int i = 0; i < 6; i++) step(1, 0, 0, 4'h0, 0, 0, "R3");
    step(0, 0, 1, 4'b0010, fld(0, 20, 0, 0), 0, "R5");     // pointer above limit
    for (int i = 0; i < 60; i++) step(1, 0, 0, 4'h0, 0, 0, "R5");
    step(0, 1, 0, 4'h0, 0, 0, "R6");
    step(1, 1, 0, 4'h0, 0, 0, "R6");
    step(1, 1, 0, 4'h0, 0, 0, "R6");
    step(1, 0, 1, 4'b0010, fld(0, 33, 0, 0), 0, "R7");
    step(1, 1, 1, 4'b0010, fld(0, 5, 0, 1), 0, "R7");
    step(0, 0, 1, 4'b1001, 32'hFFFF_FFFF, 0, "R9");
    step(0, 0, 1, 4'b0000, 32'hFFFF_FFFF, 0, "R9");
    step(0, 0, 0, 4'h0, 0, 1, "R10");
    step(0, 0, 1, 4'b0010, fld(0, 9, 1, 0) | 32'h0000_00FF, 1, "R10");
    step(1, 0, 0, 4'h0, 0, 1, "R10");
    step(1, 0, 0, 4'h0, 0, 0, "R10");
    step(0, 0, 1, 4'b0100, 32'hFFFF_FFFF, 0, "R8");        // limit 63 via lane 2
    step(0, 0, 1, 4'b0110, fld(0, 62, 0, 1), 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 4'h0, 0, 0, "R4");
    step(0, 0, 0, 4'h0, 0, 0, "R4");
    @(negedge clk); rst_n = 1'b0; #1;
    m_cnt = 0; m_bnd = 0; m_sq = 0; m_sv = 0;
    check("R1", "rd_async", rd, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(0, 0, 0, 4'h0, 0, 0, "R1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule